// File: doc/BRIEF.md
# Many-Time-Programmable Flash Programmer Sequencer

This block plays the part of an external programming station for a byte-wide many-time-programmable flash array. A single start pulse launches a fixed run: identification check, chip erase, blank check, then byte-by-byte programming with a readback verify after every byte. It drives the array's active-low chip enable, output enable and write strobe, the address and write data, and two flags that ask the board's supply logic to raise the output-enable pin or address line 9 to programming voltage. It samples the array's read data.

The bytes to be written come from a source port. The sequencer presents an address on `src_addr` and takes the byte on `src_data` in the same cycle. When the run ends, `done` rises together with exactly one of `pass` or `fail`. On a failure, `fail_addr` holds the address whose read did not match. Pulse widths and the address range are parameters counted in clock cycles and bytes.

Top module: `mtp_prog_seq`

## Requirements
- R1: While and after reset: `busy`, `done`, `pass` and `fail` are 0; `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1; both high-voltage flags are 0.
- R2: The run opens with two identification reads. Each has `mem_hv_a9`=1, `mem_hv_oe`=0, `mem_ce_n`=0 and `mem_oe_n`=0. Address 0 must return `MFR_ID` (default BFh) and address 1 must return `DEV_ID` (default C5h). A mismatch ends the run with `fail`=1, `fail_addr` set to that address, and no write pulse.
- R3: Erase is one `mem_we_n` low pulse of exactly `ERASE_CYC` cycles, with `mem_hv_oe`=1, `mem_hv_a9`=1 and `mem_ce_n`=0.
- R4: After erase and before any program pulse, every address from 0 to `DEPTH-1` is read with both flags at 0 and must return FFh. The first mismatch ends the run with `fail`=1 and `fail_addr` set to that address.
- R5: Addresses are programmed in ascending order from 0, one pulse per address. Each pulse keeps `mem_we_n` low for exactly `PROG_CYC` cycles, with `mem_hv_oe`=1, `mem_hv_a9`=0 and `mem_ce_n`=0. During the pulse, `mem_dout` equals the source byte for that address.
- R6: After each program pulse the byte is read back with both flags at 0. A mismatch ends the run with `fail`=1, `fail_addr` set to that address, and no further pulses.
- R7: The high-voltage flags never change while `mem_we_n` is low. They hold their value for at least one cycle before each falling edge and one cycle after each rising edge of `mem_we_n`.
- R8: At the end of a run, `busy` falls and `done` rises with exactly one of `pass`/`fail`. These levels hold until the next accepted start. A run with no mismatch ends with `pass`=1.
- R9: `start` is ignored while `busy` is 1. The run in progress is neither restarted nor extended.
- R10: `mem_oe_n` is never 0 while `mem_hv_oe` is 1, and `mem_we_n` is never 0 while `mem_ce_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only when idle |
| src_addr | output | AW | Address whose source byte is wanted |
| src_data | input | 8 | Source byte for `src_addr` |
| mem_ce_n | output | 1 | Array chip enable, active low |
| mem_oe_n | output | 1 | Array output enable, active low (logic level) |
| mem_we_n | output | 1 | Array write strobe, active low |
| mem_hv_oe | output | 1 | Request programming voltage on the output-enable pin |
| mem_hv_a9 | output | 1 | Request programming voltage on address line 9 |
| mem_addr | output | AW | Array address |
| mem_dout | output | 8 | Data driven to the array during a program pulse |
| mem_din | input | 8 | Data read from the array |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished; result valid |
| pass | output | 1 | Run finished without a mismatch |
| fail | output | 1 | Run stopped on a mismatch |
| fail_addr | output | AW | Address of the mismatching read |

## Verification
A wrong internal state shows up at the ports almost at once. If the state register skips or repeats a phase, the count of erase or program pulses is wrong, or programming starts before every address has been blank-read; both are visible in the same run. A bad pulse counter changes a `mem_we_n` low width, which shows up on the very next rising edge. A misrouted address counter puts a program pulse on the wrong address or corrupts `fail_addr`. Injected faults in the array model (wrong identification byte, a byte that will not erase, a bit that will not program) must stop the run at the exact address within a few cycles of the bad read.

// File: rtl/mtp_prog_pkg.sv
package mtp_prog_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ID_SET,
    S_ID_CHK,
    S_ER_SETUP,
    S_ER_PULSE,
    S_ER_HOLD,
    S_BLK_SET,
    S_BLK_CHK,
    S_PG_FETCH,
    S_PG_SETUP,
    S_PG_PULSE,
    S_PG_HOLD,
    S_VR_SET,
    S_VR_CHK
  } seq_state_t;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic hv_oe;
    logic hv_a9;
  } pin_ctl_t;

  // Pin levels the array sees in each phase of the run
  function automatic pin_ctl_t ctl_for(seq_state_t s);
    pin_ctl_t c;
    c = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, hv_oe: 1'b0, hv_a9: 1'b0};
    case (s)
      S_ID_SET, S_ID_CHK: begin
        c.ce_n  = 1'b0;
        c.oe_n  = 1'b0;
        c.hv_a9 = 1'b1;
      end
      S_ER_SETUP, S_ER_HOLD: begin
        c.ce_n  = 1'b0;
        c.hv_oe = 1'b1;
        c.hv_a9 = 1'b1;
      end
      S_ER_PULSE: begin
        c.ce_n  = 1'b0;
        c.we_n  = 1'b0;
        c.hv_oe = 1'b1;
        c.hv_a9 = 1'b1;
      end
      S_BLK_SET, S_BLK_CHK, S_VR_SET, S_VR_CHK: begin
        c.ce_n = 1'b0;
        c.oe_n = 1'b0;
      end
      S_PG_SETUP, S_PG_HOLD: begin
        c.ce_n  = 1'b0;
        c.hv_oe = 1'b1;
      end
      S_PG_PULSE: begin
        c.ce_n  = 1'b0;
        c.we_n  = 1'b0;
        c.hv_oe = 1'b1;
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mtp_pulse_timer.sv
module mtp_pulse_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/mtp_addr_walker.sv
module mtp_addr_walker #(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic          last
);
  localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)
      addr <= '0;
    else if (inc)
      addr <= addr + 1'b1;
  end

  assign last = (addr == LAST_A);
endmodule

// File: rtl/mtp_prog_seq.sv
module mtp_prog_seq
  import mtp_prog_pkg::*;
#(
  parameter int          DEPTH     = 64,
  parameter int          ERASE_CYC = 40,
  parameter int          PROG_CYC  = 6,
  parameter logic [7:0]  MFR_ID    = 8'hBF,
  parameter logic [7:0]  DEV_ID    = 8'hC5,
  localparam int         AW        = (DEPTH > 2) ? $clog2(DEPTH) : 1,
  localparam int         MAXP      = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int         CW        = $clog2(MAXP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [AW-1:0] src_addr,
  input  logic [7:0]    src_data,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_hv_oe,
  output logic          mem_hv_a9,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_dout,
  input  logic [7:0]    mem_din,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);

  seq_state_t    state, nxt;
  pin_ctl_t      ctl_q;
  logic [7:0]    wdata_q;
  logic          busy_q, done_q, pass_q, fail_q;
  logic [AW-1:0] fail_addr_q;

  logic          a_clr, a_inc, a_last;
  logic [AW-1:0] addr;
  logic          t_load, t_exp;
  logic [CW-1:0] t_val;
  logic          fin_pass, fin_fail;
  logic [7:0]    id_exp;

  mtp_addr_walker #(.DEPTH(DEPTH)) u_walk (
    .clk(clk), .rst(rst), .clr(a_clr), .inc(a_inc), .addr(addr), .last(a_last)
  );

  mtp_pulse_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  assign id_exp = addr[0] ? DEV_ID : MFR_ID;
  assign t_load = (state == S_ER_SETUP) || (state == S_PG_SETUP);
  assign t_val  = (state == S_ER_SETUP) ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);

  always_comb begin
    nxt      = state;
    a_clr    = 1'b0;
    a_inc    = 1'b0;
    fin_pass = 1'b0;
    fin_fail = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        nxt   = S_ID_SET;
        a_clr = 1'b1;
      end
      S_ID_SET: nxt = S_ID_CHK;
      S_ID_CHK: begin
        if (mem_din != id_exp) begin
          nxt      = S_IDLE;
          fin_fail = 1'b1;
        end else if (addr[0]) begin
          nxt = S_ER_SETUP;
        end else begin
          nxt   = S_ID_SET;
          a_inc = 1'b1;
        end
      end
      S_ER_SETUP: nxt = S_ER_PULSE;
      S_ER_PULSE: if (t_exp) nxt = S_ER_HOLD;
      S_ER_HOLD: begin
        nxt   = S_BLK_SET;
        a_clr = 1'b1;
      end
      S_BLK_SET: nxt = S_BLK_CHK;
      S_BLK_CHK: begin
        if (mem_din != 8'hFF) begin
          nxt      = S_IDLE;
          fin_fail = 1'b1;
        end else if (a_last) begin
          nxt   = S_PG_FETCH;
          a_clr = 1'b1;
        end else begin
          nxt   = S_BLK_SET;
          a_inc = 1'b1;
        end
      end
      S_PG_FETCH: nxt = S_PG_SETUP;
      S_PG_SETUP: nxt = S_PG_PULSE;
      S_PG_PULSE: if (t_exp) nxt = S_PG_HOLD;
      S_PG_HOLD:  nxt = S_VR_SET;
      S_VR_SET:   nxt = S_VR_CHK;
      S_VR_CHK: begin
        if (mem_din != wdata_q) begin
          nxt      = S_IDLE;
          fin_fail = 1'b1;
        end else if (a_last) begin
          nxt      = S_IDLE;
          fin_pass = 1'b1;
        end else begin
          nxt   = S_PG_FETCH;
          a_inc = 1'b1;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      ctl_q       <= ctl_for(S_IDLE);
      wdata_q     <= '0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      pass_q      <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      state  <= nxt;
      ctl_q  <= ctl_for(nxt);
      busy_q <= (nxt != S_IDLE);
      if (state == S_PG_FETCH)
        wdata_q <= src_data;
      if (state == S_IDLE && start) begin
        done_q      <= 1'b0;
        pass_q      <= 1'b0;
        fail_q      <= 1'b0;
        fail_addr_q <= '0;
      end else if (fin_pass || fin_fail) begin
        done_q <= 1'b1;
        pass_q <= fin_pass;
        fail_q <= fin_fail;
        if (fin_fail)
          fail_addr_q <= addr;
      end
    end
  end

  assign src_addr  = addr;
  assign mem_addr  = addr;
  assign mem_dout  = wdata_q;
  assign mem_ce_n  = ctl_q.ce_n;
  assign mem_oe_n  = ctl_q.oe_n;
  assign mem_we_n  = ctl_q.we_n;
  assign mem_hv_oe = ctl_q.hv_oe;
  assign mem_hv_a9 = ctl_q.hv_a9;
  assign busy      = busy_q;
  assign done      = done_q;
  assign pass      = pass_q;
  assign fail      = fail_q;
  assign fail_addr = fail_addr_q;

  // R7
  hv_pulse_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> $stable({mem_hv_oe, mem_hv_a9}));

  // R7
  hv_hold_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> $stable({mem_hv_oe, mem_hv_a9}));

  // R10
  oe_conflict_chk: assert property (@(posedge clk) disable iff (rst)
    mem_hv_oe |-> mem_oe_n);

  // R10
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_hv_oe));

  // R2
  id_read_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_hv_a9 && !mem_hv_oe) |-> (!mem_ce_n && !mem_oe_n && mem_we_n));

  // R8
  done_result_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && (pass ^ fail)));

  // R8
  idle_result_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> (!pass && !fail));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !done || $past(nxt == S_IDLE));

endmodule

// File: tb/mtp_prog_seq_test.sv
module mtp_prog_seq_test;
  localparam int DEPTH = 64;
  localparam int ERASE = 40;
  localparam int PROG  = 6;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] src_addr, mem_addr, fail_addr;
  logic [7:0] src_data, mem_dout, mem_din;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_hv_oe, mem_hv_a9;
  logic busy, done, pass, fail;

  int checks = 0;
  int fails  = 0;

  // array model and fault knobs
  logic [7:0] mem [DEPTH];
  logic [7:0] mfr_val, dev_val;
  int  er_stuck_addr, pg_stuck_addr;
  logic [7:0] pg_stuck_mask;

  // monitor results
  int er_pulses, pg_pulses, width, er_w_bad, pg_w_bad;
  int pg_order_bad, pg_data_bad, gap_bad, pin_bad, blank_seen, pg_before_blank;
  bit seen [DEPTH];
  logic prev_we;
  logic [1:0] prev_hv;

  always #5 clk = ~clk;

  function automatic logic [7:0] src_byte(int a);
    return 8'((a * 37) ^ 8'h5A);
  endfunction

  assign src_data = src_byte(int'(src_addr));

  always_comb begin
    if (!mem_ce_n && !mem_oe_n)
      mem_din = mem_hv_a9 ? (mem_addr[0] ? dev_val : mfr_val) : mem[mem_addr];
    else
      mem_din = 8'h00;
  end

  mtp_prog_seq #(.DEPTH(DEPTH), .ERASE_CYC(ERASE), .PROG_CYC(PROG),
                 .MFR_ID(8'hBF), .DEV_ID(8'hC5)) uut (
    .clk(clk), .rst(rst), .start(start), .src_addr(src_addr), .src_data(src_data),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_hv_oe(mem_hv_oe), .mem_hv_a9(mem_hv_a9), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_din(mem_din), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .fail_addr(fail_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]  = 8'h00;
      seen[i] = 1'b0;
    end
    mfr_val = 8'hBF; dev_val = 8'hC5;
    er_stuck_addr = -1; pg_stuck_addr = -1; pg_stuck_mask = 8'h00;
    er_pulses = 0; pg_pulses = 0; er_w_bad = 0; pg_w_bad = 0;
    pg_order_bad = 0; pg_data_bad = 0; gap_bad = 0; pin_bad = 0;
    blank_seen = 0; pg_before_blank = 0;
  endtask

  // monitor at the falling edge, away from the active edge
  initial begin
    prev_we = 1'b1;
    prev_hv = 2'b00;
    width   = 0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if ((!mem_oe_n && mem_hv_oe) || (!mem_we_n && mem_ce_n)) pin_bad++;
      if (!mem_we_n && prev_we) begin
        width = 1;
        if ({mem_hv_oe, mem_hv_a9} != prev_hv) gap_bad++;
        if (mem_hv_a9) begin
          er_pulses++;
          for (int i = 0; i < DEPTH; i++)
            mem[i] = (i == er_stuck_addr) ? 8'hF7 : 8'hFF;
        end else begin
          if (blank_seen != DEPTH) pg_before_blank++;
          if (int'(mem_addr) != pg_pulses) pg_order_bad++;
          if (mem_dout != src_byte(int'(mem_addr)) || mem_ce_n) pg_data_bad++;
          pg_pulses++;
          mem[mem_addr] = mem[mem_addr] & mem_dout;
          if (int'(mem_addr) == pg_stuck_addr)
            mem[mem_addr] = mem[mem_addr] | pg_stuck_mask;
        end
      end else if (!mem_we_n) begin
        width++;
        if ({mem_hv_oe, mem_hv_a9} != prev_hv) gap_bad++;
      end else if (mem_we_n && !prev_we) begin
        if ({mem_hv_oe, mem_hv_a9} != prev_hv) gap_bad++;
        if (prev_hv[0]) begin
          if (width != ERASE) er_w_bad++;
        end else begin
          if (width != PROG) pg_w_bad++;
        end
      end
      if (!mem_ce_n && !mem_oe_n && !mem_hv_a9 && !mem_hv_oe &&
          er_pulses > 0 && pg_pulses == 0 && !seen[mem_addr]) begin
        seen[mem_addr] = 1'b1;
        blank_seen++;
      end
      prev_we = mem_we_n;
      prev_hv = {mem_hv_oe, mem_hv_a9};
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_done(output bit to);
    int n = 0;
    to = 1'b0;
    while (!done) begin
      @(negedge clk);
      n++;
      if (n > 5000) begin
        to = 1'b1;
        break;
      end
    end
    @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done/pass/fail", {done, pass, fail}, 0);
    chk("R1 strobes high", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk("R1 hv flags low", {mem_hv_oe, mem_hv_a9}, 0);
  endtask

  task automatic test_good();
    bit to;
    clear_model();
    pulse_start();
    @(negedge clk);
    chk("R8 busy during run", busy, 1);
    wait_done(to);
    chk("R8 no timeout", to, 0);
    chk("R8 pass", pass, 1);
    chk("R8 fail low", fail, 0);
    chk("R8 busy low at end", busy, 0);
    chk("R3 one erase pulse", er_pulses, 1);
    chk("R3 erase width", er_w_bad, 0);
    chk("R4 all addresses blank-read", blank_seen, DEPTH);
    chk("R4 no program before blank check", pg_before_blank, 0);
    chk("R5 program pulse count", pg_pulses, DEPTH);
    chk("R5 program width", pg_w_bad, 0);
    chk("R5 ascending order", pg_order_bad, 0);
    chk("R5 data and ce", pg_data_bad, 0);
    chk("R7 hv setup/hold gaps", gap_bad, 0);
    chk("R10 pin conflicts", pin_bad, 0);
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) if (mem[i] != src_byte(i)) bad++;
      chk("R6 array content matches source", bad, 0);
    end
    repeat (5) @(negedge clk);
    chk("R8 result held", {done, pass, fail}, 6);
  endtask

  task automatic test_busy_start();
    bit to;
    clear_model();
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_start();
    repeat (300) @(negedge clk);
    pulse_start();
    wait_done(to);
    chk("R9 no timeout", to, 0);
    chk("R9 single erase", er_pulses, 1);
    chk("R9 program count unchanged", pg_pulses, DEPTH);
    chk("R9 pass", pass, 1);
  endtask

  task automatic test_bad_id(input bit dev);
    bit to;
    clear_model();
    if (dev) dev_val = 8'hC6; else mfr_val = 8'h1F;
    pulse_start();
    wait_done(to);
    chk("R2 no timeout", to, 0);
    chk("R2 fail", fail, 1);
    chk("R2 fail_addr", fail_addr, dev ? 1 : 0);
    chk("R2 no write pulse", er_pulses + pg_pulses, 0);
  endtask

  task automatic test_blank_fail();
    bit to;
    clear_model();
    er_stuck_addr = 9;
    pulse_start();
    wait_done(to);
    chk("R4 no timeout", to, 0);
    chk("R4 fail", fail, 1);
    chk("R4 fail_addr", fail_addr, 9);
    chk("R4 no program pulse", pg_pulses, 0);
  endtask

  task automatic test_verify_fail(input int a);
    bit to;
    clear_model();
    pg_stuck_addr = a;
    pg_stuck_mask = ~src_byte(a);
    pulse_start();
    wait_done(to);
    chk("R6 no timeout", to, 0);
    chk("R6 fail", fail, 1);
    chk("R6 pass low", pass, 0);
    chk("R6 fail_addr", fail_addr, a);
    chk("R6 stops after failing byte", pg_pulses, a + 1);
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    test_reset();
    test_good();
    test_busy_start();
    test_bad_id(1'b0);
    test_bad_id(1'b1);
    test_blank_fail();
    test_verify_fail(5);
    test_verify_fail(DEPTH - 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule